// File: doc/BRIEF.md
# Dual-Loop Phase/Frequency Detector with Lock Indication

This block holds the digital comparison logic for two synthesizer loops, a main loop and an auxiliary loop. Each loop has its own phase/frequency detector. The detector takes a one-cycle reference pulse and a one-cycle divider pulse, both synchronous to the reference-input clock. It drives an up and a down pump-enable signal. Once both enables are set, the detector keeps them both active for a programmable backlash interval and then clears them. This gives the analog pumps a guaranteed minimum on-time in every cycle, so there is no dead zone around zero phase error.

A lock monitor follows each loop. A comparison cycle is good when there was no clock period in which only one of the two enables was active, which means the phase error was under one reference-input period. A loop is reported locked after four good cycles in a row. The lock is withdrawn at the end of the first bad cycle. The two loop results are merged according to the per-loop power enables and a 2-bit output mode. The mode can select combined push-pull, combined open-drain, main loop only or auxiliary loop only. For the open-drain case the block provides an output level and a separate output enable. The main loop also has an integral pump enable pair, which a pump-ratio control bit can hold off.

Top module: `pfdLock`

## Requirements
- R1: A reference pulse seen at a clock edge sets the loop's up enable after that edge, and a divider pulse sets its down enable. An enable stays set until the loop clears both enables together.
- R2: Once up and down are both set, both stay set for exactly BACKLASH clock cycles (default 2) and are then cleared together. A pulse that arrives at the clearing edge sets its enable again at that same edge.
- R3: A comparison cycle is good when no cycle with exactly one enable active occurred since the previous clear. A loop reports lock after LOCK_CYCLES (default 4) consecutive good cycles, and its lock drops at the end of the first bad cycle.
- R4: With both loops powered, the combined lock is the AND of the main and auxiliary lock.
- R5: A powered-down loop has both pump enables at 0 and loses its lock history. With one loop powered down, the combined lock follows the other loop alone. With both powered down, the combined lock is 0.
- R6: lockMode 2'b00 gives push-pull combined lock: lockOe=1 and lockOut is the combined lock. 2'b01 gives open-drain combined lock: lockOut=0 and lockOe is the inverse of the combined lock. 2'b10 outputs the main lock and 2'b11 outputs the auxiliary lock, both with lockOe=1.
- R7: While intPumpDisable=1, mainIntUp and mainIntDn are 0. While it is 0, they equal mainUp and mainDn.
- R8: While reset is held (rstN=0), all pump enables are 0 and no loop reports lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-input clock |
| rstN | input | 1 | Synchronous reset, active low |
| mainRefPulse | input | 1 | Reference comparison pulse for the main loop |
| mainDivPulse | input | 1 | Main divider output pulse |
| auxRefPulse | input | 1 | Reference comparison pulse for the auxiliary loop |
| auxDivPulse | input | 1 | Auxiliary divider output pulse |
| mainPwr | input | 1 | Main loop powered (1) or down (0) |
| auxPwr | input | 1 | Auxiliary loop powered (1) or down (0) |
| lockMode | input | 2 | Lock output mode, encoding as in R6 |
| intPumpDisable | input | 1 | Pump-ratio bit that holds off the main integral pump |
| mainUp | output | 1 | Main normal pump up enable |
| mainDn | output | 1 | Main normal pump down enable |
| mainIntUp | output | 1 | Main integral pump up enable |
| mainIntDn | output | 1 | Main integral pump down enable |
| auxUp | output | 1 | Auxiliary pump up enable |
| auxDn | output | 1 | Auxiliary pump down enable |
| lockOut | output | 1 | Lock output level |
| lockOe | output | 1 | Lock output driver enable |

## Verification
The detectors are driven with several pulse patterns. Reference and divider pulses landing in the same cycle check the pure backlash pulse and the lock build-up. A divider that lags by one or more cycles checks up-first behaviour and the loss of lock. A divider that leads checks down-first behaviour. Pulses spaced exactly one backlash apart land on the clearing edge and check that a new pulse wins over the clear. A phase of random skews and power changes then checks each loop independently. The mode and power sweeps separate the AND combination, the single-loop fallback and the open-drain drive, all of which would look the same in push-pull with both loops locked.

// File: rtl/pfdPkg.sv
package pfdPkg;
  localparam int NUM_LOOPS = 2;
  localparam int MAIN_IDX = 0;
  localparam int AUX_IDX = 1;

  typedef enum logic [1:0] {
    LK_PUSHPULL  = 2'b00,
    LK_OPENDRAIN = 2'b01,
    LK_MAINONLY  = 2'b10,
    LK_AUXONLY   = 2'b11
  } lockMode_e;

  // per-loop strobes from control to datapath and lock evaluation
  typedef struct packed {
    logic clr;   // end of comparison cycle, clear both enables
    logic hold;  // loop powered down, keep everything cleared
  } loopStrobe_t;
endpackage

// File: rtl/pfdControl.sv
module pfdControl
  import pfdPkg::*;
#(
  parameter int BACKLASH = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_LOOPS-1:0]         pwr,
  input  logic [NUM_LOOPS-1:0]         up,
  input  logic [NUM_LOOPS-1:0]         dn,
  output loopStrobe_t [NUM_LOOPS-1:0]  strobe
);
  localparam int BL_W = (BACKLASH > 1) ? $clog2(BACKLASH) : 1;
  localparam logic [BL_W-1:0] BL_LAST = BL_W'(BACKLASH - 1);

  for (genvar l = 0; l < NUM_LOOPS; l++) begin : gLoop
    logic [BL_W-1:0] blCnt;
    logic bothOn;
    logic endCycle;

    assign bothOn = up[l] & dn[l];
    assign endCycle = bothOn && (blCnt == BL_LAST);

    always_ff @(posedge clk) begin
      if (!rstN || !pwr[l]) begin
        blCnt <= '0;
      end else if (endCycle || !bothOn) begin
        blCnt <= '0;
      end else begin
        blCnt <= blCnt + 1'b1;
      end
    end

    assign strobe[l].clr = endCycle & pwr[l];
    assign strobe[l].hold = ~pwr[l];
  end
endmodule

// File: rtl/pfdDatapath.sv
module pfdDatapath
  import pfdPkg::*;
#(
  parameter int MISMATCH_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_LOOPS-1:0]         refPulse,
  input  logic [NUM_LOOPS-1:0]         divPulse,
  input  loopStrobe_t [NUM_LOOPS-1:0]  strobe,
  output logic [NUM_LOOPS-1:0]         up,
  output logic [NUM_LOOPS-1:0]         dn,
  output logic [NUM_LOOPS-1:0]         cycleGood
);
  localparam logic [MISMATCH_W-1:0] MIS_MAX = '1;

  for (genvar l = 0; l < NUM_LOOPS; l++) begin : gLoop
    logic upQ, dnQ;
    logic [MISMATCH_W-1:0] misCnt;

    always_ff @(posedge clk) begin
      if (!rstN || strobe[l].hold) begin
        upQ <= 1'b0;
        dnQ <= 1'b0;
      end else begin
        upQ <= (upQ & ~strobe[l].clr) | refPulse[l];
        dnQ <= (dnQ & ~strobe[l].clr) | divPulse[l];
      end
    end

    // clock periods with only one enable active in this comparison cycle
    always_ff @(posedge clk) begin
      if (!rstN || strobe[l].hold || strobe[l].clr) begin
        misCnt <= '0;
      end else if ((upQ ^ dnQ) && (misCnt != MIS_MAX)) begin
        misCnt <= misCnt + 1'b1;
      end
    end

    assign up[l] = upQ;
    assign dn[l] = dnQ;
    assign cycleGood[l] = (misCnt == '0);
  end
endmodule

// File: rtl/lockEval.sv
module lockEval
  import pfdPkg::*;
#(
  parameter int LOCK_CYCLES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  loopStrobe_t [NUM_LOOPS-1:0]  strobe,
  input  logic [NUM_LOOPS-1:0]         cycleGood,
  input  logic [1:0]                   lockMode,
  output logic                         lockOut,
  output logic                         lockOe
);
  localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [GOOD_W-1:0] GOOD_FULL = GOOD_W'(LOCK_CYCLES);

  logic [NUM_LOOPS-1:0] loopLocked;
  logic [NUM_LOOPS-1:0] loopOn;
  logic combined;
  lockMode_e modeSel;

  for (genvar l = 0; l < NUM_LOOPS; l++) begin : gLoop
    logic [GOOD_W-1:0] goodCnt;

    always_ff @(posedge clk) begin
      if (!rstN || strobe[l].hold) begin
        goodCnt <= '0;
      end else if (strobe[l].clr) begin
        if (!cycleGood[l]) goodCnt <= '0;
        else if (goodCnt != GOOD_FULL) goodCnt <= goodCnt + 1'b1;
      end
    end

    assign loopOn[l] = ~strobe[l].hold;
    assign loopLocked[l] = loopOn[l] && (goodCnt == GOOD_FULL);
  end

  always_comb begin
    unique case (loopOn)
      2'b11:   combined = loopLocked[MAIN_IDX] & loopLocked[AUX_IDX];
      2'b01:   combined = loopLocked[MAIN_IDX];
      2'b10:   combined = loopLocked[AUX_IDX];
      default: combined = 1'b0;
    endcase
  end

  assign modeSel = lockMode_e'(lockMode);

  always_comb begin
    lockOe = 1'b1;
    unique case (modeSel)
      LK_PUSHPULL:  lockOut = combined;
      LK_OPENDRAIN: begin
        lockOut = 1'b0;
        lockOe = ~combined;
      end
      LK_MAINONLY:  lockOut = loopLocked[MAIN_IDX];
      LK_AUXONLY:   lockOut = loopLocked[AUX_IDX];
      default:      lockOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfdLock.sv
module pfdLock
  import pfdPkg::*;
#(
  parameter int BACKLASH = 2,
  parameter int LOCK_CYCLES = 4,
  parameter int MISMATCH_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mainRefPulse,
  input  logic       mainDivPulse,
  input  logic       auxRefPulse,
  input  logic       auxDivPulse,
  input  logic       mainPwr,
  input  logic       auxPwr,
  input  logic [1:0] lockMode,
  input  logic       intPumpDisable,
  output logic       mainUp,
  output logic       mainDn,
  output logic       mainIntUp,
  output logic       mainIntDn,
  output logic       auxUp,
  output logic       auxDn,
  output logic       lockOut,
  output logic       lockOe
);
  loopStrobe_t [NUM_LOOPS-1:0] strobe;
  logic [NUM_LOOPS-1:0] up, dn, cycleGood, pwr, refPulse, divPulse;

  assign pwr = {auxPwr, mainPwr};
  assign refPulse = {auxRefPulse, mainRefPulse};
  assign divPulse = {auxDivPulse, mainDivPulse};

  pfdControl #(.BACKLASH(BACKLASH)) uCtrl (
    .clk(clk), .rstN(rstN), .pwr(pwr), .up(up), .dn(dn), .strobe(strobe)
  );

  pfdDatapath #(.MISMATCH_W(MISMATCH_W)) uDp (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .divPulse(divPulse),
    .strobe(strobe), .up(up), .dn(dn), .cycleGood(cycleGood)
  );

  lockEval #(.LOCK_CYCLES(LOCK_CYCLES)) uLock (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cycleGood(cycleGood),
    .lockMode(lockMode), .lockOut(lockOut), .lockOe(lockOe)
  );

  assign mainUp = up[MAIN_IDX];
  assign mainDn = dn[MAIN_IDX];
  assign auxUp = up[AUX_IDX];
  assign auxDn = dn[AUX_IDX];
  assign mainIntUp = up[MAIN_IDX] & ~intPumpDisable;
  assign mainIntDn = dn[MAIN_IDX] & ~intPumpDisable;
endmodule

// File: rtl/pfdLockChecker.sv
module pfdLockChecker #(
  parameter int BACKLASH = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       mainRefPulse,
  input logic       auxDivPulse,
  input logic       mainPwr,
  input logic       auxPwr,
  input logic [1:0] lockMode,
  input logic       intPumpDisable,
  input logic       mainUp,
  input logic       mainDn,
  input logic       mainIntUp,
  input logic       mainIntDn,
  input logic       auxDn,
  input logic       lockOut,
  input logic       lockOe
);
  // R1
  up_needs_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainUp) |-> $past(mainRefPulse));
  // R1
  dn_needs_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(auxDn) |-> $past(auxDivPulse));
  // R2
  backlash_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (BACKLASH > 1) && $rose(mainUp && mainDn) |=> (mainUp && mainDn));
  // R5
  powered_down_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mainPwr |=> (!mainUp && !mainDn));
  // R5
  both_down_no_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mainPwr && !auxPwr) |-> (lockMode == 2'b01 ? lockOe : !lockOut));
  // R6
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockMode == 2'b01) |-> !lockOut);
  // R6
  driven_modes_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockMode != 2'b01) |-> lockOe);
  // R7
  int_pump_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    intPumpDisable |-> (!mainIntUp && !mainIntDn));
endmodule

bind pfdLock pfdLockChecker #(.BACKLASH(BACKLASH)) uChk (
  .clk(clk), .rstN(rstN), .mainRefPulse(mainRefPulse), .auxDivPulse(auxDivPulse),
  .mainPwr(mainPwr), .auxPwr(auxPwr), .lockMode(lockMode),
  .intPumpDisable(intPumpDisable), .mainUp(mainUp), .mainDn(mainDn),
  .mainIntUp(mainIntUp), .mainIntDn(mainIntDn), .auxDn(auxDn),
  .lockOut(lockOut), .lockOe(lockOe)
);

// File: tb/tb_pfdLock.sv
module tb_pfdLock;
  localparam int BACKLASH = 2;
  localparam int LOCKN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] refP = '0, divP = '0, pwr = 2'b11;
  logic [1:0] lockMode = 2'b00;
  logic intPumpDisable = 1'b0;
  logic mainUp, mainDn, mainIntUp, mainIntDn, auxUp, auxDn, lockOut, lockOe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfdLock dut (
    .clk(clk), .rstN(rstN),
    .mainRefPulse(refP[0]), .mainDivPulse(divP[0]),
    .auxRefPulse(refP[1]), .auxDivPulse(divP[1]),
    .mainPwr(pwr[0]), .auxPwr(pwr[1]), .lockMode(lockMode),
    .intPumpDisable(intPumpDisable),
    .mainUp(mainUp), .mainDn(mainDn), .mainIntUp(mainIntUp), .mainIntDn(mainIntDn),
    .auxUp(auxUp), .auxDn(auxDn), .lockOut(lockOut), .lockOe(lockOe)
  );

  // behavioural reference model of each loop
  bit mUp[2], mDn[2], mBad[2];
  int mHeld[2], mGood[2];

  always @(posedge clk) begin
    for (int l = 0; l < 2; l++) begin
      if (!rstN || !pwr[l]) begin
        mUp[l] = 0; mDn[l] = 0; mBad[l] = 0; mHeld[l] = 0; mGood[l] = 0;
      end else begin
        bit both, fin;
        both = mUp[l] && mDn[l];
        fin = both && (mHeld[l] + 1 == BACKLASH);
        if (fin) mGood[l] = mBad[l] ? 0 : ((mGood[l] < LOCKN) ? mGood[l] + 1 : LOCKN);
        mBad[l] = fin ? 1'b0 : (mBad[l] || (mUp[l] != mDn[l]));
        mHeld[l] = (both && !fin) ? mHeld[l] + 1 : 0;
        mUp[l] = (mUp[l] && !fin) || refP[l];
        mDn[l] = (mDn[l] && !fin) || divP[l];
      end
    end
  end

  function automatic bit mLocked(int l);
    return pwr[l] && (mGood[l] >= LOCKN);
  endfunction

  function automatic bit mCombined();
    if (pwr == 2'b11) return mLocked(0) && mLocked(1);
    if (pwr == 2'b01) return mLocked(0);
    if (pwr == 2'b10) return mLocked(1);
    return 1'b0;
  endfunction

  task automatic cmp(string tag, string what, logic act, logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    string lt;
    bit eOut, eOe;
    vectors++;
    cmp((mUp[0] && mDn[0]) ? "R2" : (rstN ? "R1" : "R8"), "mainUp", mainUp, mUp[0]);
    cmp((mUp[0] && mDn[0]) ? "R2" : (rstN ? "R1" : "R8"), "mainDn", mainDn, mDn[0]);
    cmp((mUp[1] && mDn[1]) ? "R2" : (pwr[1] ? "R1" : "R5"), "auxUp", auxUp, mUp[1]);
    cmp((mUp[1] && mDn[1]) ? "R2" : (pwr[1] ? "R1" : "R5"), "auxDn", auxDn, mDn[1]);
    cmp("R7", "mainIntUp", mainIntUp, mUp[0] && !intPumpDisable);
    cmp("R7", "mainIntDn", mainIntDn, mDn[0] && !intPumpDisable);
    eOe = 1'b1;
    case (lockMode)
      2'b00: eOut = mCombined();
      2'b01: begin eOut = 1'b0; eOe = !mCombined(); end
      2'b10: eOut = mLocked(0);
      default: eOut = mLocked(1);
    endcase
    if (!rstN) lt = "R8";
    else if (lockMode != 2'b00) lt = "R6";
    else if (pwr != 2'b11) lt = "R5";
    else lt = "R4";
    cmp(lt, "lockOut", lockOut, eOut);
    cmp(lt, "lockOe", lockOe, eOe);
  endtask

  // one clock: check outputs away from the edge, then drive next inputs
  task automatic step(logic [1:0] r, logic [1:0] d);
    @(negedge clk);
    compareAll();
    refP = r;
    divP = d;
  endtask

  // periods with per-loop reference and divider offsets inside the period
  task automatic burst(int n, int per, int mR, int mD, int aR, int aD);
    for (int p = 0; p < n; p++)
      for (int t = 0; t < per; t++)
        step({t == aR, t == mR}, {t == aD, t == mD});
  endtask

  task automatic expectBit(string tag, string what, logic act, logic exp);
    vectors++;
    cmp(tag, what, act, exp);
  endtask

  initial begin
    repeat (3) step(2'b00, 2'b00);
    expectBit("R8", "reset mainUp", mainUp, 1'b0);
    expectBit("R8", "reset lockOut", lockOut, 1'b0);
    rstN = 1'b1;
    // aligned pulses: lock builds over LOCKN cycles
    burst(3, 8, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R3", "lock after 3 good cycles", lockOut, 1'b0);
    burst(3, 8, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R3", "lock after 6 good cycles", lockOut, 1'b1);
    // main divider lags one cycle: lock drops
    burst(1, 8, 0, 1, 0, 0);
    burst(1, 8, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R3", "lock dropped after bad cycle", lockOut, 1'b0);
    // divider leads on aux, lagging by 3 on main
    burst(3, 8, 1, 4, 2, 0);
    // pulses spaced one backlash apart land on the clearing edge
    burst(6, BACKLASH, 0, 0, 0, 0);
    burst(6, 8, 0, 0, 0, 0);
    // mode sweep while locked
    for (int m = 0; m < 4; m++) begin
      lockMode = 2'(m);
      burst(1, 8, 0, 0, 0, 0);
    end
    lockMode = 2'b00;
    // aux unlocked: combined follows AND
    burst(2, 8, 0, 0, 0, 2);
    @(negedge clk);
    expectBit("R4", "AND with aux unlocked", lockOut, 1'b0);
    // aux powered down: main alone decides
    pwr = 2'b01;
    burst(2, 8, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R5", "main alone decides", lockOut, 1'b1);
    expectBit("R5", "powered-down aux idle", auxUp, 1'b0);
    pwr = 2'b00;
    burst(2, 8, 0, 0, 0, 0);
    @(negedge clk);
    expectBit("R5", "both down low", lockOut, 1'b0);
    lockMode = 2'b01;
    @(negedge clk);
    expectBit("R6", "open-drain both down releases never", lockOe, 1'b1);
    lockMode = 2'b00;
    pwr = 2'b10;
    burst(6, 8, 0, 0, 3, 3);
    pwr = 2'b11;
    intPumpDisable = 1'b1;
    burst(3, 8, 0, 2, 0, 0);
    intPumpDisable = 1'b0;
    // random skews, modes and power
    for (int k = 0; k < 400; k++) begin
      int mr, md, ar, ad;
      mr = $urandom_range(0, 1); md = $urandom_range(0, 1);
      ar = $urandom_range(0, 1); ad = $urandom_range(0, 1);
      if (k % 25 == 0) begin
        lockMode = 2'($urandom_range(0, 3));
        pwr = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : 2'b11;
        intPumpDisable = 1'($urandom_range(0, 1));
      end
      burst(1, 6, mr, md, ar, ad);
    end
    step(2'b00, 2'b00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule